// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is an on-chip scratchpad split into sixteen banks of 32-bit words, shared by sixteen lanes. Each lane presents an enable, a word address, a read/write select and write data; the whole group is taken as one request in a single cycle. The word address is split so that neighbouring words sit in neighbouring banks. Each bank serves one distinct address per cycle.

When lanes collide on a bank at different addresses, the block spreads the request over as many service cycles as the worst bank needs. Lanes that share an address are served together in one access, so a broadcast read costs nothing extra. While a request is spread out, a stall output holds off the next request. At the end, a one-cycle completion pulse comes with per-lane read data and the number of service cycles used.

Typical use is a tile buffer for matrix work. Reading one column of a 16×16 row-major tile hits a single bank sixteen times. With rows padded to 17 words, the same column read spreads across all banks and completes in one service cycle.

Top module: `scratch_serializer`

## Requirements
- R1: The bank index of a word address is its low 4 bits (address modulo 16), and the remaining upper bits select the word inside that bank.
- R2: A request whose enabled lanes all address different banks completes with a reported degree of 1.
- R3: The reported degree equals, over all banks, the largest number of distinct addresses that enabled lanes present to one bank. A request with no enabled lane reports 1. Strides 2 and 8 report 2 and 8. A column of a 16×16 tile reports 16, and the same column with 17-word rows reports 1.
- R4: Enabled lanes that read the same address count as one access and add no cycles.
- R5: Every enabled reading lane receives the word as it stood before the request, even when another lane of the same request writes that address.
- R6: When several enabled lanes of one request write the same address, the value from the highest-numbered of them is stored.
- R7: A request is taken when req_valid is high and busy is low. busy is then high for exactly degree+1 cycles, and req_valid is ignored while busy is high.
- R8: done is a one-cycle pulse on the cycle after busy falls. degree and the read data of the request are valid with it.
- R9: After reset, busy, done and degree are 0.
- R10: A lane whose enable is low neither writes memory nor adds to the degree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Offers a request; taken when busy is low |
| lane_en | input | LANES | Per-lane enable |
| lane_we | input | LANES | Per-lane write select (1 = write) |
| lane_addr | input | LANES*ADDR_W | Per-lane word address, lane 0 in the low bits |
| lane_wdata | input | LANES*DATA_W | Per-lane write data, lane 0 in the low bits |
| busy | output | 1 | Stall: a request is being served |
| done | output | 1 | One-cycle completion pulse |
| degree | output | clog2(LANES+1) | Service cycles the last request used |
| rd_data | output | LANES*DATA_W | Per-lane read data, lane 0 in the low bits |

## Verification
The assertions take for granted that the lane inputs may change freely while busy is high. They rely only on the latched copy of the request, and they assume reset is held for at least one clock before the first request. The bench changes inputs only on falling edges. It deliberately drives req_valid and a conflicting write while the block is busy, to show that such offers are dropped. Memory is never read before the bench has written it, so no check depends on unreset storage.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_LANES  = 16;
  localparam int unsigned SP_BANKS  = 16;
  localparam int unsigned SP_ADDR_W = 8;
  localparam int unsigned SP_DATA_W = 32;
endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 2 ** ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wd;
      rd <= mem[row];
    end
  end
endmodule

// File: rtl/sp_arbiter.sv
module sp_arbiter #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [LANES-1:0]                     pend,
  input  logic [LANES*ADDR_W-1:0]              addr,
  input  logic [LANES-1:0]                     we,
  input  logic [LANES*DATA_W-1:0]              wd,
  output logic [LANES-1:0]                     grant,
  output logic [BANKS-1:0]                     bank_en,
  output logic [BANKS-1:0]                     bank_we,
  output logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0] bank_row,
  output logic [BANKS*DATA_W-1:0]              bank_wd
);
  localparam int BSEL_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BSEL_W;

  logic [BANKS*LANES-1:0] gnt_all;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              found;
    logic [ADDR_W-1:0] lead;
    logic [LANES-1:0]  gb;
    logic              w;
    logic [DATA_W-1:0] d;

    always_comb begin
      found = 1'b0;
      lead  = '0;
      gb    = '0;
      w     = 1'b0;
      d     = '0;
      // lowest pending lane on this bank picks the address
      for (int l = 0; l < LANES; l++) begin
        if (!found && pend[l] &&
            addr[l*ADDR_W +: BSEL_W] == BSEL_W'(b)) begin
          found = 1'b1;
          lead  = addr[l*ADDR_W +: ADDR_W];
        end
      end
      // every pending lane at that address rides along; last writer wins
      for (int l = 0; l < LANES; l++) begin
        if (found && pend[l] && addr[l*ADDR_W +: ADDR_W] == lead) begin
          gb[l] = 1'b1;
          if (we[l]) begin
            w = 1'b1;
            d = wd[l*DATA_W +: DATA_W];
          end
        end
      end
    end

    assign gnt_all[b*LANES +: LANES] = gb;
    assign bank_en[b]                = found;
    assign bank_we[b]                = w;
    assign bank_row[b*ROW_W +: ROW_W] = lead[ADDR_W-1:BSEL_W];
    assign bank_wd[b*DATA_W +: DATA_W] = d;
  end

  always_comb begin
    grant = '0;
    for (int b = 0; b < BANKS; b++) grant |= gnt_all[b*LANES +: LANES];
  end
endmodule

// File: rtl/scratch_serializer.sv
module scratch_serializer #(
  parameter int LANES  = sp_pkg::SP_LANES,
  parameter int BANKS  = sp_pkg::SP_BANKS,
  parameter int ADDR_W = sp_pkg::SP_ADDR_W,
  parameter int DATA_W = sp_pkg::SP_DATA_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [LANES-1:0]            lane_en,
  input  logic [LANES-1:0]            lane_we,
  input  logic [LANES*ADDR_W-1:0]     lane_addr,
  input  logic [LANES*DATA_W-1:0]     lane_wdata,
  output logic                        busy,
  output logic                        done,
  output logic [$clog2(LANES+1)-1:0]  degree,
  output logic [LANES*DATA_W-1:0]     rd_data
);
  localparam int BSEL_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BSEL_W;
  localparam int DEG_W  = $clog2(LANES+1);

  logic                    act, tail;
  logic [LANES-1:0]        pend, gnt_d, grant, left;
  logic [LANES*ADDR_W-1:0] q_addr;
  logic [LANES-1:0]        q_we;
  logic [LANES*DATA_W-1:0] q_wd;
  logic [DEG_W-1:0]        deg_cnt;
  logic                    accept;

  logic [BANKS-1:0]        bank_en, bank_we;
  logic [BANKS*ROW_W-1:0]  bank_row;
  logic [BANKS*DATA_W-1:0] bank_wd, bank_rd;

  assign busy   = act | tail;
  assign accept = req_valid & ~busy;
  assign left   = pend & ~grant;

  sp_arbiter #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .pend(pend), .addr(q_addr), .we(q_we), .wd(q_wd), .grant(grant),
    .bank_en(bank_en), .bank_we(bank_we), .bank_row(bank_row), .bank_wd(bank_wd)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_ram
    sp_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
      .clk(clk), .en(bank_en[b]), .we(bank_we[b]),
      .row(bank_row[b*ROW_W +: ROW_W]), .wd(bank_wd[b*DATA_W +: DATA_W]),
      .rd(bank_rd[b*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      tail    <= 1'b0;
      pend    <= '0;
      gnt_d   <= '0;
      deg_cnt <= '0;
      done    <= 1'b0;
      degree  <= '0;
      rd_data <= '0;
      q_addr  <= '0;
      q_we    <= '0;
      q_wd    <= '0;
    end else begin
      done  <= 1'b0;
      gnt_d <= act ? grant : '0;
      if (accept) begin
        act     <= 1'b1;
        pend    <= lane_en;
        q_addr  <= lane_addr;
        q_we    <= lane_we;
        q_wd    <= lane_wdata;
        deg_cnt <= '0;
      end else if (act) begin
        pend    <= left;
        deg_cnt <= deg_cnt + DEG_W'(1);
        if (left == '0) begin
          act  <= 1'b0;
          tail <= 1'b1;
        end
      end
      if (tail) begin
        tail   <= 1'b0;
        done   <= 1'b1;
        degree <= deg_cnt;
      end
      // bank outputs are one cycle behind the grant that addressed them
      for (int l = 0; l < LANES; l++) begin
        if (gnt_d[l] && !q_we[l])
          rd_data[l*DATA_W +: DATA_W] <=
            bank_rd[q_addr[l*ADDR_W +: BSEL_W]*DATA_W +: DATA_W];
      end
    end
  end

  assert_grant_subset_R3: assert property (@(posedge clk) disable iff (rst)
    act |-> ((grant & ~pend) == '0));
  assert_progress_R3: assert property (@(posedge clk) disable iff (rst)
    (act && pend != '0) |-> (grant != '0));
  assert_pend_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
    (act && pend != '0) |=> ($countones(pend) < $past($countones(pend))));
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  assert_busy_ends_R7: assert property (@(posedge clk) disable iff (rst)
    tail |=> !busy);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_degree_range_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (degree != '0 && degree <= DEG_W'(LANES)));
endmodule

// File: tb/scratch_serializer_test.sv
module scratch_serializer_test;
  localparam int L = 16;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [L-1:0] lane_en = '0, lane_we = '0;
  logic [L*AW-1:0] lane_addr = '0;
  logic [L*DW-1:0] lane_wdata = '0;
  logic busy, done;
  logic [4:0] degree;
  logic [L*DW-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [256];
  logic [AW-1:0] a [L];
  logic          en [L], we [L];
  logic [DW-1:0] d [L];

  always #2 clk = ~clk;

  scratch_serializer uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .lane_en(lane_en), .lane_we(lane_we),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata), .busy(busy), .done(done),
    .degree(degree), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  function automatic int exp_degree();
    int best = 1;
    for (int b = 0; b < 16; b++) begin
      int cnt = 0;
      for (int i = 0; i < L; i++) begin
        if (en[i] && (a[i] % 16) == b) begin
          bit first = 1'b1;
          for (int j = 0; j < i; j++) if (en[j] && a[j] == a[i]) first = 1'b0;
          if (first) cnt++;
        end
      end
      if (cnt > best) best = cnt;
    end
    return best;
  endfunction

  task automatic clear_lanes();
    for (int l = 0; l < L; l++) begin
      a[l] = '0; en[l] = 1'b0; we[l] = 1'b0; d[l] = '0;
    end
  endtask

  task automatic run(input int want_deg, input string req, input bit inject);
    int cnt = 0;
    int guard = 0;
    logic [DW-1:0] exp_rd [L];
    @(negedge clk);
    for (int l = 0; l < L; l++) begin
      lane_en[l] = en[l];
      lane_we[l] = we[l];
      lane_addr[l*AW +: AW] = a[l];
      lane_wdata[l*DW +: DW] = d[l];
      exp_rd[l] = model[a[l]];
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      // R7: an offer made while busy must be dropped
      lane_en = '1; lane_we = '1;
      for (int l = 0; l < L; l++) begin
        lane_addr[l*AW +: AW] = 8'd200;
        lane_wdata[l*DW +: DW] = 32'hBAD0_0000 + l;
      end
      req_valid = 1'b1;
    end
    while (!done && guard < 100) begin
      if (busy) cnt++;
      if (inject && cnt == 3) req_valid = 1'b0;
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    check(guard < 100, {req, " done seen"}, guard, 0);
    check(degree == want_deg, {req, " degree"}, degree, want_deg);
    check(cnt == want_deg + 1, "R7 busy cycles", cnt, want_deg + 1);
    @(negedge clk);
    check(!done, "R8 done one cycle", done, 0);
    for (int l = 0; l < L; l++)
      if (en[l] && !we[l])
        check(rd_data[l*DW +: DW] == exp_rd[l], "R5 read data", rd_data[l*DW +: DW], exp_rd[l]);
    for (int l = 0; l < L; l++)
      if (en[l] && we[l]) model[a[l]] = d[l];
  endtask

  task automatic read_back(input int base, input string req);
    clear_lanes();
    for (int l = 0; l < L; l++) begin
      a[l] = AW'(base + l); en[l] = 1'b1;
    end
    run(1, req, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy == 0, "R9 busy reset", busy, 0);
    check(done == 0, "R9 done reset", done, 0);
    check(degree == 0, "R9 degree reset", degree, 0);

    // R1 R2: fill memory with unit-stride writes, one cycle each
    for (int k = 0; k < 16; k++) begin
      clear_lanes();
      for (int l = 0; l < L; l++) begin
        a[l] = AW'(k*16 + l); en[l] = 1'b1; we[l] = 1'b1;
        d[l] = 32'h1000_0000 + (k*16 + l) * 3 + 7;
      end
      run(1, "R2 fill", 1'b0);
    end

    // R3: stride sweep, degree computed per bank
    for (int s = 1; s <= 16; s++) begin
      clear_lanes();
      for (int l = 0; l < L; l++) begin
        a[l] = AW'((3 + l*s) % 256); en[l] = 1'b1;
      end
      run(exp_degree(), "R3 stride", 1'b0);
    end
    clear_lanes();
    for (int l = 0; l < L; l++) begin a[l] = AW'(l*2); en[l] = 1'b1; end
    run(2, "R3 stride2", 1'b0);
    clear_lanes();
    for (int l = 0; l < L; l++) begin a[l] = AW'(l*8); en[l] = 1'b1; end
    run(8, "R3 stride8", 1'b0);

    // R3: tile column versus padded column
    clear_lanes();
    for (int l = 0; l < L; l++) begin a[l] = AW'(l*16 + 5); en[l] = 1'b1; end
    run(16, "R3 column", 1'b0);
    clear_lanes();
    for (int l = 0; l < L; l++) begin a[l] = AW'((l*17 + 5) % 256); en[l] = 1'b1; end
    run(1, "R3 padded column", 1'b0);

    // R4: full and partial broadcast
    clear_lanes();
    for (int l = 0; l < L; l++) begin a[l] = 8'd77; en[l] = 1'b1; end
    run(1, "R4 broadcast", 1'b0);
    clear_lanes();
    for (int l = 0; l < L; l++) begin a[l] = AW'(16 * (l % 4)); en[l] = 1'b1; end
    run(4, "R4 partial broadcast", 1'b0);

    // R6: all lanes write one address, highest lane wins
    clear_lanes();
    for (int l = 0; l < L; l++) begin
      a[l] = 8'd40; en[l] = 1'b1; we[l] = 1'b1; d[l] = 32'hC000_0000 + l;
    end
    run(1, "R6 write clash", 1'b0);
    check(model[40] == 32'hC000_000F, "R6 model", model[40], 32'hC000_000F);
    read_back(40, "R6 readback");

    // R5: reads and writes to one address in one request
    clear_lanes();
    for (int l = 0; l < L; l++) begin
      a[l] = 8'd90; en[l] = 1'b1; we[l] = (l >= 8); d[l] = 32'hE000_0000 + l;
    end
    run(1, "R5 mixed", 1'b0);
    read_back(90, "R5 readback");

    // R10: disabled lanes neither write nor add cycles
    clear_lanes();
    for (int l = 0; l < L; l++) begin
      en[l] = (l % 2 == 0);
      we[l] = (l % 2 == 1);
      a[l] = (l % 2 == 0) ? AW'(100 + l) : AW'(16 * l + 4);
      d[l] = 32'hDEAD_0000 + l;
    end
    run(1, "R10 disabled", 1'b0);
    for (int k = 0; k < 16; k++) read_back(k*16, "R10 readback");
    clear_lanes();
    run(1, "R10 empty", 1'b0);

    // R7: offer while busy is ignored
    clear_lanes();
    for (int l = 0; l < L; l++) begin a[l] = AW'(l*16 + 9); en[l] = 1'b1; end
    run(16, "R7 busy column", 1'b1);
    read_back(192, "R7 readback");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule